// File: doc/BRIEF.md
# Receive Packet Buffer Byte Writer

This block sits between a receive PHY byte stream and one port of a dual-port on-chip RAM that holds received packets. The RAM is carved into a fixed number of equal slots (eight slots of 4 KB by default, 32 KB in all). Each slot's base address is the slot index times the slot size. At the start of a packet the writer captures the target slot index and a header offset. The header offset leaves room at the front of the slot for metadata that software keeps there. The first received byte lands at that offset, and each following byte lands at the next byte address.

The RAM port is a direct 64-bit word port with one byte-enable per lane. It does not pass through any bus fabric. Bytes are gathered little-endian into a word register. A word is written as soon as its top lane fills, or at end-of-packet with only the lanes that were received enabled, so a packet may start and end at any byte alignment. Bytes that would fall past the end of the slot are dropped and an overflow flag is raised. At the end of the packet the writer pulses a done strobe and shows the number of bytes it actually wrote. It also shows where the payload proper begins: the header offset plus a fixed PHY header size, inside the chosen slot.

Top module: `pkt_buf_writer`

## Requirements
- R1: A byte at slot byte offset `b` of slot `s` is written to RAM word `s*(SLOT_BYTES/LANES) + b/LANES`, presented on `ram_addr`.
- R2: The first byte of a packet goes to slot byte offset `hdr_offset`. Each later byte of the packet goes to the next byte offset.
- R3: One cycle after the start of a packet is accepted, `payload_addr` equals `slot*SLOT_BYTES + hdr_offset + PHY_HDR_BYTES` as a RAM byte address. It holds that value until the next packet starts.
- R4: The byte at offset `b` sits in lane `b % LANES`, which is bits `[8*lane+7 : 8*lane]` of `ram_wdata`, with `ram_be[lane]` set. Lanes that are not enabled carry zero. While `ram_we` is low, `ram_addr`, `ram_be` and `ram_wdata` are all zero.
- R5: A word is written in the cycle after the byte for its top lane is accepted. A partial final word is written in the cycle after the end-of-packet byte is accepted, with enables only for the lanes received.
- R6: `done` is high for exactly one cycle, the cycle after the end-of-packet byte is accepted. `byte_count` then equals the number of bytes written for that packet and holds until the next packet starts.
- R7: Bytes that fall at or beyond the slot end are not written and are not counted. `overflow` is high from the cycle after the first dropped byte until the next packet starts.
- R8: The slot index and header offset are sampled only when a packet starts. Changing them during a packet has no effect on that packet.
- R9: A start marker that arrives while a packet is in progress is treated as an ordinary data byte of the current packet.
- R10: Valid bytes without a start marker while no packet is in progress are ignored. No write occurs and `byte_count`, `overflow` and `payload_addr` are unchanged.
- R11: While reset is asserted and after it is released, all outputs are zero until a packet starts.
- R12: Cycles with `in_valid` low inside a packet neither write nor advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_offset | input | OFF_W | Metadata size in bytes, sampled at packet start |
| slot_sel | input | SLOT_W | Target slot index, sampled at packet start |
| in_valid | input | 1 | A byte is present on `in_byte` |
| in_sop | input | 1 | This byte starts a packet |
| in_eop | input | 1 | This byte ends a packet |
| in_byte | input | 8 | Received byte |
| ram_we | output | 1 | RAM word write strobe |
| ram_addr | output | WORD_W | RAM word address |
| ram_be | output | LANES | Per-lane byte enables |
| ram_wdata | output | 8*LANES | Write data, little-endian lanes |
| done | output | 1 | One-cycle end-of-packet pulse |
| byte_count | output | OFF_W+1 | Bytes written in the current or last packet |
| overflow | output | 1 | A byte of this packet fell beyond the slot |
| payload_addr | output | BYTE_AW+1 | RAM byte address where the payload begins |

## Verification
The bench builds the writer with four slots of 256 bytes, eight lanes and a four-byte PHY header. The small slot lets a packet run off the end of the last slot within a few cycles, so the dropped-byte path, the overflow flag and the word-index wrap into the slot field are all exercised. Header offsets such as 5 and 250 place the first and last bytes in the middle of a word. This covers every partial-enable pattern at both ends of a packet, together with gaps, mid-packet parameter changes and back-to-back packets.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    localparam int unsigned BYTE_W          = 8;
    localparam int unsigned DEF_NUM_SLOTS   = 8;
    localparam int unsigned DEF_SLOT_BYTES  = 4096;
    localparam int unsigned DEF_LANES       = 8;
    localparam int unsigned DEF_PHY_HDR     = 16;

    // Bytes left in a slot from a byte offset; used for sizing checks.
    function automatic int unsigned room_left(int unsigned slot_bytes, int unsigned off);
        return (off >= slot_bytes) ? 0 : slot_bytes - off;
    endfunction
endpackage

// File: rtl/pbw_ctrl.sv
module pbw_ctrl
    import pbw_pkg::*;
#(
    parameter int unsigned NUM_SLOTS     = DEF_NUM_SLOTS,
    parameter int unsigned SLOT_BYTES    = DEF_SLOT_BYTES,
    parameter int unsigned LANES         = DEF_LANES,
    parameter int unsigned PHY_HDR_BYTES = DEF_PHY_HDR,
    localparam int unsigned SLOT_W  = $clog2(NUM_SLOTS),
    localparam int unsigned OFF_W   = $clog2(SLOT_BYTES),
    localparam int unsigned CUR_W   = OFF_W + 1,
    localparam int unsigned LANE_W  = $clog2(LANES),
    localparam int unsigned WORD_W  = SLOT_W + OFF_W - LANE_W,
    localparam int unsigned BYTE_AW = SLOT_W + OFF_W,
    localparam int unsigned PAY_W   = BYTE_AW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OFF_W-1:0]    hdr_offset,
    input  logic [SLOT_W-1:0]   slot_sel,
    input  logic                in_valid,
    input  logic                in_sop,
    input  logic                in_eop,
    output logic                put_o,
    output logic [LANE_W-1:0]   lane_o,
    output logic [WORD_W-1:0]   word_o,
    output logic                flush_o,
    output logic                done_o,
    output logic [CUR_W-1:0]    count_o,
    output logic                ovf_o,
    output logic [PAY_W-1:0]    paddr_o
);
    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] slot;
        logic [CUR_W-1:0]  cursor;
        logic [CUR_W-1:0]  count;
        logic              ovf;
        logic              done;
        logic [PAY_W-1:0]  paddr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic              accept;
    logic              start;
    logic [CUR_W-1:0]  cur;
    logic [SLOT_W-1:0] slot_now;
    logic              in_rng;

    always_comb begin
        accept   = in_valid && (st_q.active || in_sop);
        start    = accept && !st_q.active;
        cur      = start ? {1'b0, hdr_offset} : st_q.cursor;
        slot_now = start ? slot_sel : st_q.slot;
        in_rng   = cur < CUR_W'(SLOT_BYTES);

        put_o    = accept && in_rng;
        lane_o   = cur[LANE_W-1:0];
        word_o   = {slot_now, cur[OFF_W-1:LANE_W]};
        flush_o  = accept && in_eop;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.active = 1'b1;
            st_d.slot   = slot_sel;
            st_d.count  = '0;
            st_d.ovf    = 1'b0;
            st_d.paddr  = PAY_W'({slot_sel, hdr_offset}) + PAY_W'(PHY_HDR_BYTES);
        end
        if (accept) begin
            if (in_rng) begin
                st_d.cursor = cur + CUR_W'(1);
                st_d.count  = st_d.count + CUR_W'(1);
            end else begin
                st_d.cursor = cur;
                st_d.ovf    = 1'b1;
            end
            if (in_eop) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o  = st_q.done;
    assign count_o = st_q.count;
    assign ovf_o   = st_q.ovf;
    assign paddr_o = st_q.paddr;

    assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CUR_W'(SLOT_BYTES));

    assert_done_ends_packet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.active);

    assert_ovf_at_slot_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> st_q.cursor == CUR_W'(SLOT_BYTES));
endmodule

// File: rtl/pbw_pack.sv
module pbw_pack
    import pbw_pkg::*;
#(
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned WORD_W = 12,
    localparam int unsigned LANE_W = $clog2(LANES),
    localparam int unsigned DATA_W = BYTE_W * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                put_i,
    input  logic [LANE_W-1:0]   lane_i,
    input  logic [WORD_W-1:0]   word_i,
    input  logic                flush_i,
    input  logic [BYTE_W-1:0]   byte_i,
    output logic                ram_we,
    output logic [WORD_W-1:0]   ram_addr,
    output logic [LANES-1:0]    ram_be,
    output logic [DATA_W-1:0]   ram_wdata
);
    typedef struct packed {
        logic [DATA_W-1:0] acc_data;
        logic [LANES-1:0]  acc_be;
        logic [WORD_W-1:0] acc_word;
        logic              we;
        logic [WORD_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } pack_t;

    pack_t pk_d, pk_q;

    logic [DATA_W-1:0] m_data;
    logic [LANES-1:0]  m_be;
    logic [WORD_W-1:0] m_word;
    logic              emit;

    always_comb begin
        m_data = pk_q.acc_data;
        m_be   = pk_q.acc_be;
        m_word = pk_q.acc_word;
        if (put_i) m_word = word_i;
        for (int i = 0; i < LANES; i++) begin
            if (put_i && lane_i == LANE_W'(i)) begin
                m_data[i*BYTE_W +: BYTE_W] = byte_i;
                m_be[i]                    = 1'b1;
            end
        end
        emit = (put_i && lane_i == LANE_W'(LANES-1)) || (flush_i && (|m_be));

        pk_d       = pk_q;
        pk_d.we    = 1'b0;
        pk_d.addr  = '0;
        pk_d.be    = '0;
        pk_d.wdata = '0;
        if (emit) begin
            pk_d.we       = 1'b1;
            pk_d.addr     = m_word;
            pk_d.be       = m_be;
            pk_d.wdata    = m_data;
            pk_d.acc_data = '0;
            pk_d.acc_be   = '0;
            pk_d.acc_word = m_word;
        end else begin
            pk_d.acc_data = m_data;
            pk_d.acc_be   = m_be;
            pk_d.acc_word = m_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign ram_we    = pk_q.we;
    assign ram_addr  = pk_q.addr;
    assign ram_be    = pk_q.be;
    assign ram_wdata = pk_q.wdata;

    assert_write_has_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pk_q.we |-> (|pk_q.be));

    assert_quiet_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pk_q.we |-> (pk_q.be == '0 && pk_q.wdata == '0 && pk_q.addr == '0));

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (pk_q.acc_be == '0));
endmodule

// File: rtl/pkt_buf_writer.sv
module pkt_buf_writer
    import pbw_pkg::*;
#(
    parameter int unsigned NUM_SLOTS     = DEF_NUM_SLOTS,
    parameter int unsigned SLOT_BYTES    = DEF_SLOT_BYTES,
    parameter int unsigned LANES         = DEF_LANES,
    parameter int unsigned PHY_HDR_BYTES = DEF_PHY_HDR,
    localparam int unsigned SLOT_W  = $clog2(NUM_SLOTS),
    localparam int unsigned OFF_W   = $clog2(SLOT_BYTES),
    localparam int unsigned CUR_W   = OFF_W + 1,
    localparam int unsigned LANE_W  = $clog2(LANES),
    localparam int unsigned WORD_W  = SLOT_W + OFF_W - LANE_W,
    localparam int unsigned BYTE_AW = SLOT_W + OFF_W,
    localparam int unsigned PAY_W   = BYTE_AW + 1,
    localparam int unsigned DATA_W  = BYTE_W * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OFF_W-1:0]    hdr_offset,
    input  logic [SLOT_W-1:0]   slot_sel,
    input  logic                in_valid,
    input  logic                in_sop,
    input  logic                in_eop,
    input  logic [BYTE_W-1:0]   in_byte,
    output logic                ram_we,
    output logic [WORD_W-1:0]   ram_addr,
    output logic [LANES-1:0]    ram_be,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                done,
    output logic [CUR_W-1:0]    byte_count,
    output logic                overflow,
    output logic [PAY_W-1:0]    payload_addr
);
    logic              put;
    logic [LANE_W-1:0] lane;
    logic [WORD_W-1:0] word;
    logic              flush;

    pbw_ctrl #(
        .NUM_SLOTS    (NUM_SLOTS),
        .SLOT_BYTES   (SLOT_BYTES),
        .LANES        (LANES),
        .PHY_HDR_BYTES(PHY_HDR_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_offset(hdr_offset),
        .slot_sel  (slot_sel),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .put_o     (put),
        .lane_o    (lane),
        .word_o    (word),
        .flush_o   (flush),
        .done_o    (done),
        .count_o   (byte_count),
        .ovf_o     (overflow),
        .paddr_o   (payload_addr)
    );

    pbw_pack #(
        .LANES (LANES),
        .WORD_W(WORD_W)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .put_i    (put),
        .lane_i   (lane),
        .word_i   (word),
        .flush_i  (flush),
        .byte_i   (in_byte),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .ram_be   (ram_be),
        .ram_wdata(ram_wdata)
    );

    assert_write_on_put_or_eop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(put || flush));
endmodule

// File: tb/pkt_buf_writer_bench.sv
module pkt_buf_writer_bench;
    localparam int NS = 4;
    localparam int SB = 256;
    localparam int LN = 8;
    localparam int PH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  hdr_offset = '0;
    logic [1:0]  slot_sel = '0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        ram_we;
    logic [6:0]  ram_addr;
    logic [7:0]  ram_be;
    logic [63:0] ram_wdata;
    logic        done;
    logic [8:0]  byte_count;
    logic        overflow;
    logic [10:0] payload_addr;

    always #10 clk = ~clk;

    pkt_buf_writer #(.NUM_SLOTS(NS), .SLOT_BYTES(SB), .LANES(LN), .PHY_HDR_BYTES(PH)) u_pkt_buf_writer (
        .clk(clk), .rst_n(rst_n), .hdr_offset(hdr_offset), .slot_sel(slot_sel),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_byte(in_byte),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be), .ram_wdata(ram_wdata),
        .done(done), .byte_count(byte_count), .overflow(overflow), .payload_addr(payload_addr)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    bit    started = 0;
    bit    finished = 0;
    string scen = "R11";

    // behavioural reference state
    bit          m_active = 0;
    int          m_slot = 0, m_cur = 0, m_cnt = 0, m_word = 0;
    bit          m_ovf = 0;
    logic [7:0]  m_be = '0;
    logic [63:0] m_data = '0;
    bit          e_we = 0, e_done = 0;
    int          e_addr = 0, e_paddr = 0;
    logic [7:0]  e_be = '0;
    logic [63:0] e_data = '0;

    task automatic check_eq(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s actual=%0h expected=%0h at %0t", req, scen, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_active = 0; m_slot = 0; m_cur = 0; m_cnt = 0; m_word = 0; m_ovf = 0;
            m_be = '0; m_data = '0; e_we = 0; e_done = 0; e_addr = 0; e_paddr = 0;
            e_be = '0; e_data = '0;
        end else begin
            e_we = 0; e_addr = 0; e_be = '0; e_data = '0; e_done = 0;
            if (in_valid && (m_active || in_sop)) begin
                if (!m_active) begin
                    m_active = 1; m_slot = slot_sel; m_cur = hdr_offset; m_cnt = 0; m_ovf = 0;
                    e_paddr = m_slot * SB + m_cur + PH;
                end
                if (m_cur < SB) begin
                    int ln;
                    ln = m_cur % LN;
                    m_data[ln*8 +: 8] = in_byte;
                    m_be[ln] = 1'b1;
                    m_word = m_slot * (SB / LN) + m_cur / LN;
                    m_cnt++; m_cur++;
                    if (ln == LN - 1 || in_eop) begin
                        e_we = 1; e_addr = m_word; e_be = m_be; e_data = m_data;
                        m_be = '0; m_data = '0;
                    end
                end else begin
                    m_ovf = 1;
                    if (in_eop && m_be != 0) begin
                        e_we = 1; e_addr = m_word; e_be = m_be; e_data = m_data;
                        m_be = '0; m_data = '0;
                    end
                end
                if (in_eop) begin e_done = 1; m_active = 0; end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            check_eq("R5", "ram_we", ram_we, e_we);
            check_eq("R1", "ram_addr", ram_addr, e_addr);
            check_eq("R4", "ram_be", ram_be, e_be);
            check_eq("R4", "ram_wdata", ram_wdata, e_data);
            check_eq("R6", "done", done, e_done);
            check_eq("R6", "byte_count", byte_count, m_cnt);
            check_eq("R7", "overflow", overflow, m_ovf);
            check_eq("R3", "payload_addr", payload_addr, e_paddr);
        end
    end

    task automatic send_pkt(int slot, int off, int len, int gap, bit mutate, bit midsop,
                            bit chain, int seed, int exp_cnt, bit exp_ovf);
        for (int i = 0; i < len; i++) begin
            if (gap > 0 && i > 0 && i % gap == 0) begin
                @(negedge clk);
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_byte = 8'hA5;
            end
            @(negedge clk);
            if (i == 0) begin slot_sel = 2'(slot); hdr_offset = 8'(off); end
            if (mutate && i == 1) begin slot_sel = ~slot_sel; hdr_offset = hdr_offset ^ 8'h3C; end
            in_valid = 1'b1;
            in_sop   = (i == 0) || (midsop && i == len / 2);
            in_eop   = (i == len - 1);
            in_byte  = 8'((seed + i * 37) & 255);
        end
        if (!chain) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
            check_eq("R6", "done after eop", done, 1);
            check_eq("R6", "final count", byte_count, exp_cnt);
            check_eq("R7", "final overflow", overflow, exp_ovf);
            check_eq("R3", "payload start", payload_addr, slot * SB + off + PH);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R11", "ram_we in reset", ram_we, 0);
        check_eq("R11", "byte_count in reset", byte_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R11", "payload_addr after reset", payload_addr, 0);

        scen = "R2";
        send_pkt(0, 0, 16, 0, 0, 0, 0, 1, 16, 0);
        scen = "R12";
        send_pkt(3, 5, 13, 3, 0, 0, 0, 2, 13, 0);
        scen = "R8";
        send_pkt(1, 11, 20, 0, 1, 0, 0, 3, 20, 0);
        scen = "R5";
        send_pkt(1, 7, 1, 0, 0, 0, 0, 4, 1, 0);

        scen = "R10";
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_eop = (k == 4); in_byte = 8'(k);
            slot_sel = 2'd2; hdr_offset = 8'd9;
        end
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        check_eq("R10", "no write while idle", ram_we, 0);
        check_eq("R10", "count unchanged", byte_count, 1);
        check_eq("R10", "payload unchanged", payload_addr, 1 * SB + 7 + PH);

        scen = "R9";
        send_pkt(2, 3, 18, 0, 0, 1, 0, 5, 18, 0);
        scen = "R7";
        send_pkt(3, 250, 12, 0, 0, 0, 0, 6, 6, 1);
        send_pkt(2, 254, 5, 2, 0, 0, 0, 7, 2, 1);
        scen = "R6";
        send_pkt(0, 13, 9, 0, 0, 0, 1, 8, 9, 0);
        send_pkt(3, 2, 10, 0, 0, 0, 0, 9, 10, 0);
        scen = "R1";
        send_pkt(3, 200, 40, 0, 0, 0, 0, 10, 40, 0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule